// File: doc/BRIEF.md
# Multi-Channel Interrupt Pulse Combiner

This block sits between a multi-channel Ethernet MAC and the CPU's interrupt controller. The MAC raises one level request per channel and per request class. The block gathers those requests into four classes: receive threshold, receive, transmit and miscellaneous. Each class has its own per-channel enable mask. Each class drives one CPU-facing pulse interrupt.

A class output gives a single-cycle pulse when the class goes from no enabled request pending to at least one. After the pulse the output is disarmed, and stays so until software writes an end-of-interrupt code that names that class. Software reads the masked status of a class to learn which channels need service. It services them, then writes the code for that class. The MAC holds each request until its channel is serviced. If anything is still pending when the code is written, the block pulses again at once. The block does not latch requests per channel.

A small word-addressed register bus gives access to the enable masks, the masked status and the end-of-interrupt vector. Reads are combinational. Writes take effect at the clock edge.

Top module: `irq_pulse_combiner`

## Requirements
- R1: After reset, all four enable masks are zero, every status and enable offset reads zero, all four interrupt outputs are low, and every class is armed.
- R2: The masked status of each class reads as its raw request vector ANDed with its enable mask, with bit i standing for channel i. The status words sit at word offsets 4 (receive threshold), 5 (receive), 6 (transmit) and 7 (miscellaneous).
- R3: The enable masks sit at word offsets 0 (receive threshold), 1 (receive), 2 (transmit) and 3 (miscellaneous). Each reads back the low NUM_CH bits last written. All read data above bit NUM_CH-1 is zero.
- R4: When an armed class's masked status becomes non-zero, its output goes high at the next clock edge for exactly one cycle.
- R5: After a pulse, the class raises no further pulse until its end-of-interrupt code is written, whatever its requests do.
- R6: A write to word offset 8 re-arms exactly one class: value 0 re-arms receive threshold, 1 receive, 2 transmit and 3 miscellaneous. The other classes are unaffected.
- R7: If a class's masked status is non-zero when its end-of-interrupt write is taken, its output goes high at the next clock edge after the write edge, for one cycle.
- R8: An end-of-interrupt value greater than 3 re-arms no class.
- R9: A write to a status offset changes no enable mask and no status.
- R10: A request on a channel whose enable bit is zero causes no pulse and does not show in the status.
- R11: Offset 8 and unmapped offsets read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Word offset |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, combinational from reg_addr |
| rxthr_req | input | NUM_CH | Raw receive-threshold requests, one per channel |
| rx_req | input | NUM_CH | Raw receive requests, one per channel |
| tx_req | input | NUM_CH | Raw transmit requests, one per channel |
| misc_req | input | NUM_CH | Raw miscellaneous requests, one per source |
| irq_rxthr | output | 1 | Receive-threshold pulse interrupt |
| irq_rx | output | 1 | Receive pulse interrupt |
| irq_tx | output | 1 | Transmit pulse interrupt |
| irq_misc | output | 1 | Miscellaneous pulse interrupt |

## Verification
The bench builds the block with its defaults: eight channels per class, a 32-bit data bus and a 4-bit word offset. With these values, channel 7 is the top edge of every mask, and bits 8 to 31 of each read are available to show that they stay zero. All nine mapped offsets and the unmapped offsets above them fit inside the 4-bit offset range. The largest ignored end-of-interrupt value is also reachable.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  // Class index; also the end-of-interrupt code that re-arms the class.
  typedef enum logic [1:0] {
    CLS_RXTHR = 2'd0,
    CLS_RX    = 2'd1,
    CLS_TX    = 2'd2,
    CLS_MISC  = 2'd3
  } irq_cls_e;

  localparam int NUM_CLS  = 4;
  localparam int OFS_EN   = 0;  // enable masks at OFS_EN + class
  localparam int OFS_STAT = 4;  // masked status at OFS_STAT + class
  localparam int OFS_EOI  = 8;  // end-of-interrupt vector

endpackage

// File: rtl/irqc_regfile.sv
module irqc_regfile
  import irqc_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              reg_wr,
  input  logic [ADDR_W-1:0]                 reg_addr,
  input  logic [DATA_W-1:0]                 reg_wdata,
  input  logic [NUM_CLS-1:0][NUM_CH-1:0]    masked,
  output logic [NUM_CLS-1:0][NUM_CH-1:0]    en_q,
  output logic [NUM_CLS-1:0]                eoi_hit,
  output logic [DATA_W-1:0]                 reg_rdata
);

  logic [NUM_CLS-1:0][NUM_CH-1:0] en_d;
  logic [NUM_CLS-1:0]             en_wr;
  logic                           eoi_sel;

  assign eoi_sel = reg_wr && (reg_addr == ADDR_W'(OFS_EOI));

  for (genvar g = 0; g < NUM_CLS; g++) begin : g_cls
    assign en_wr[g]   = reg_wr && (reg_addr == ADDR_W'(OFS_EN + g));
    assign eoi_hit[g] = eoi_sel && (reg_wdata == DATA_W'(g));
  end

  // next-state for the enable masks
  always_comb begin
    en_d = en_q;
    for (int g = 0; g < NUM_CLS; g++) begin
      if (en_wr[g]) begin
        en_d[g] = reg_wdata[NUM_CH-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (|en_wr) begin
      en_q <= en_d;
    end
  end

  // read mux; unmapped offsets and the vector read as zero
  always_comb begin
    reg_rdata = '0;
    for (int g = 0; g < NUM_CLS; g++) begin
      if (reg_addr == ADDR_W'(OFS_EN + g)) begin
        reg_rdata = DATA_W'(en_q[g]);
      end
      if (reg_addr == ADDR_W'(OFS_STAT + g)) begin
        reg_rdata = DATA_W'(masked[g]);
      end
    end
  end

endmodule

// File: rtl/irqc_pulse_gen.sv
module irqc_pulse_gen #(
  parameter int NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] masked,
  input  logic              eoi_hit,
  output logic              irq
);

  logic armed_q, armed_d;
  logic irq_q;
  logic fire;

  assign fire = armed_q && (|masked);

  // firing disarms; a simultaneous vector write loses to it
  always_comb begin
    armed_d = armed_q;
    if (fire) begin
      armed_d = 1'b0;
    end else if (eoi_hit) begin
      armed_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b1;
      irq_q   <= 1'b0;
    end else begin
      armed_q <= armed_d;
      irq_q   <= fire;
    end
  end

  assign irq = irq_q;

endmodule

// File: rtl/irq_pulse_combiner.sv
module irq_pulse_combiner
  import irqc_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [NUM_CH-1:0] rxthr_req,
  input  logic [NUM_CH-1:0] rx_req,
  input  logic [NUM_CH-1:0] tx_req,
  input  logic [NUM_CH-1:0] misc_req,
  output logic              irq_rxthr,
  output logic              irq_rx,
  output logic              irq_tx,
  output logic              irq_misc
);

  logic [NUM_CLS-1:0][NUM_CH-1:0] raw;
  logic [NUM_CLS-1:0][NUM_CH-1:0] en_q;
  logic [NUM_CLS-1:0][NUM_CH-1:0] masked;
  logic [NUM_CLS-1:0]             eoi_hit;
  logic [NUM_CLS-1:0]             irq_vec;

  assign raw[CLS_RXTHR] = rxthr_req;
  assign raw[CLS_RX]    = rx_req;
  assign raw[CLS_TX]    = tx_req;
  assign raw[CLS_MISC]  = misc_req;

  irqc_regfile #(
    .NUM_CH (NUM_CH),
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .masked    (masked),
    .en_q      (en_q),
    .eoi_hit   (eoi_hit),
    .reg_rdata (reg_rdata)
  );

  for (genvar g = 0; g < NUM_CLS; g++) begin : g_cls
    assign masked[g] = raw[g] & en_q[g];

    irqc_pulse_gen #(
      .NUM_CH (NUM_CH)
    ) u_pulse (
      .clk     (clk),
      .rst_n   (rst_n),
      .masked  (masked[g]),
      .eoi_hit (eoi_hit[g]),
      .irq     (irq_vec[g])
    );
  end

  assign irq_rxthr = irq_vec[CLS_RXTHR];
  assign irq_rx    = irq_vec[CLS_RX];
  assign irq_tx    = irq_vec[CLS_TX];
  assign irq_misc  = irq_vec[CLS_MISC];

endmodule

// File: rtl/irqc_checker.sv
module irqc_checker
  import irqc_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           reg_wr,
  input logic [ADDR_W-1:0]              reg_addr,
  input logic [DATA_W-1:0]              reg_wdata,
  input logic [DATA_W-1:0]              reg_rdata,
  input logic [NUM_CLS-1:0][NUM_CH-1:0] en_q,
  input logic [NUM_CLS-1:0][NUM_CH-1:0] masked,
  input logic [NUM_CLS-1:0]             irq_vec
);

  logic stat_wr;
  logic bad_eoi_wr;
  assign stat_wr    = reg_wr && (reg_addr >= ADDR_W'(OFS_STAT)) &&
                      (reg_addr < ADDR_W'(OFS_STAT + NUM_CLS));
  assign bad_eoi_wr = reg_wr && (reg_addr == ADDR_W'(OFS_EOI)) &&
                      (reg_wdata > DATA_W'(NUM_CLS - 1));

  for (genvar g = 0; g < NUM_CLS; g++) begin : g_chk
    // R4: a pulse lasts one cycle
    a_r4_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      irq_vec[g] |=> !irq_vec[g]);

    // R10: a pulse needs an enabled request in the cycle before
    a_r10_needs_enabled: assert property (@(posedge clk) disable iff (!rst_n)
      irq_vec[g] |-> $past(|masked[g]));
  end

  // R9: status writes leave the masks alone
  a_r9_stat_write: assert property (@(posedge clk) disable iff (!rst_n)
    stat_wr |=> $stable(en_q));

  // R8: an out-of-range vector leaves the masks alone
  a_r8_bad_code: assert property (@(posedge clk) disable iff (!rst_n)
    bad_eoi_wr |=> $stable(en_q));

  // R3: read data above the channel bits is zero
  a_r3_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata >> NUM_CH) == '0);

endmodule

bind irq_pulse_combiner irqc_checker #(
  .NUM_CH (NUM_CH),
  .DATA_W (DATA_W),
  .ADDR_W (ADDR_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .en_q      (en_q),
  .masked    (masked),
  .irq_vec   (irq_vec)
);

// File: tb/irq_pulse_combiner_tb.sv
module irq_pulse_combiner_tb;

  localparam int NCH = 8;
  localparam int DW  = 32;
  localparam int AW  = 4;

  // word offsets and codes as the requirements give them
  localparam int A_EN_THR = 0, A_EN_RX = 1, A_EN_TX = 2, A_EN_MISC = 3;
  localparam int A_ST_THR = 4, A_ST_RX = 5, A_ST_TX = 6, A_ST_MISC = 7;
  localparam int A_EOI    = 8;

  logic          clk;
  logic          rst_n;
  logic          reg_wr;
  logic [AW-1:0] reg_addr;
  logic [DW-1:0] reg_wdata;
  logic [DW-1:0] reg_rdata;
  logic [NCH-1:0] rxthr_req, rx_req, tx_req, misc_req;
  logic irq_rxthr, irq_rx, irq_tx, irq_misc;

  int total = 0;
  int bad   = 0;

  irq_pulse_combiner #(.NUM_CH(NCH), .DATA_W(DW), .ADDR_W(AW)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .rxthr_req (rxthr_req),
    .rx_req    (rx_req),
    .tx_req    (tx_req),
    .misc_req  (misc_req),
    .irq_rxthr (irq_rxthr),
    .irq_rx    (irq_rx),
    .irq_tx    (irq_tx),
    .irq_misc  (irq_misc)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] irqs();
    return {irq_misc, irq_tx, irq_rx, irq_rxthr};
  endfunction

  // write: one cycle strobe, returns at the negedge after the write edge
  task automatic wr(int addr, logic [DW-1:0] data);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = AW'(addr); reg_wdata = data;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd_check(string req, int addr, logic [DW-1:0] exp);
    reg_addr = AW'(addr);
    #1;
    check(req, reg_rdata, exp);
  endtask

  task automatic quiet_cycles(string req, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(req, {28'd0, irqs()}, '0);
    end
  endtask

  // drop everything and re-arm every class
  task automatic clean();
    @(negedge clk);
    rxthr_req = '0; rx_req = '0; tx_req = '0; misc_req = '0;
    for (int a = 0; a < 4; a++) wr(a, '0);
    for (int c = 0; c < 4; c++) wr(A_EOI, DW'(c));
  endtask

  task automatic t_reset();
    for (int a = 0; a < 8; a++) rd_check("R1 reset read", a, '0);
    check("R1 reset irqs", {28'd0, irqs()}, '0);
  endtask

  task automatic t_enable_rw();
    wr(A_EN_THR, 32'hFFFF_FF81);
    wr(A_EN_RX,  32'h0000_0042);
    wr(A_EN_TX,  32'h1234_5624);
    wr(A_EN_MISC, 32'h0000_0018);
    rd_check("R3 thr enable", A_EN_THR, 32'h81);
    rd_check("R3 rx enable", A_EN_RX, 32'h42);
    rd_check("R3 tx enable", A_EN_TX, 32'h24);
    rd_check("R3 misc enable", A_EN_MISC, 32'h18);
    rd_check("R11 eoi read", A_EOI, '0);
    rd_check("R11 unmapped read", 12, '0);
    rd_check("R11 unmapped read", 15, '0);
    clean();
  endtask

  task automatic t_status_mask();
    wr(A_EN_RX, 32'hF0);
    wr(A_EN_TX, 32'h0F);
    @(negedge clk);
    rx_req = 8'h3C; tx_req = 8'hA5; rxthr_req = 8'hFF; misc_req = 8'h81;
    rd_check("R2 rx status", A_ST_RX, 32'h30);
    rd_check("R2 tx status", A_ST_TX, 32'h05);
    rd_check("R10 thr status disabled", A_ST_THR, '0);
    rd_check("R10 misc status disabled", A_ST_MISC, '0);
    clean();
  endtask

  task automatic t_disabled();
    wr(A_EN_TX, 32'h7F);
    @(negedge clk);
    tx_req = 8'h80;  // channel 7 is masked off
    quiet_cycles("R10 disabled no pulse", 3);
    rd_check("R10 disabled status", A_ST_TX, '0);
    clean();
  endtask

  task automatic t_pulse_and_disarm();
    wr(A_EN_TX, 32'hFF);
    tx_req = 8'h80;
    @(negedge clk);
    check("R4 tx pulse", {28'd0, irqs()}, 32'h4);
    @(negedge clk);
    check("R4 tx pulse ends", {28'd0, irqs()}, '0);
    tx_req = 8'h81;
    quiet_cycles("R5 disarmed more requests", 2);
    tx_req = 8'h00;
    quiet_cycles("R5 disarmed drop", 2);
    tx_req = 8'h02;
    quiet_cycles("R5 disarmed re-raise", 3);
    // R7: vector write with pending request
    wr(A_EOI, 32'd2);
    check("R7 not yet", {28'd0, irqs()}, '0);
    @(negedge clk);
    check("R7 tx repulse", {28'd0, irqs()}, 32'h4);
    @(negedge clk);
    check("R7 repulse ends", {28'd0, irqs()}, '0);
    clean();
  endtask

  task automatic t_eoi_select();
    for (int a = 0; a < 4; a++) wr(a, 32'hFF);
    @(negedge clk);
    rxthr_req = 8'h01; rx_req = 8'h01; tx_req = 8'h01; misc_req = 8'h01;
    @(negedge clk);
    check("R4 all classes pulse", {28'd0, irqs()}, 32'hF);
    quiet_cycles("R5 all disarmed", 2);
    wr(A_EOI, 32'd4);
    quiet_cycles("R8 code 4 ignored", 3);
    wr(A_EOI, 32'hFFFF_FFFF);
    quiet_cycles("R8 large code ignored", 2);
    for (int c = 0; c < 4; c++) begin
      wr(A_EOI, DW'(c));
      @(negedge clk);
      check("R6 only named class re-armed", {28'd0, irqs()}, 32'(1 << c));
      @(negedge clk);
    end
    clean();
  endtask

  task automatic t_status_write();
    wr(A_EN_RX, 32'h55);
    @(negedge clk);
    rx_req = 8'hFF;
    @(negedge clk);
    check("R4 rx pulse", {28'd0, irqs()}, 32'h2);
    for (int a = 4; a < 8; a++) wr(a, 32'hFFFF_FFFF);
    rd_check("R9 rx status unchanged", A_ST_RX, 32'h55);
    rd_check("R9 rx enable unchanged", A_EN_RX, 32'h55);
    rd_check("R9 tx enable unchanged", A_EN_TX, '0);
    check("R9 no re-arm", {28'd0, irqs()}, '0);
    clean();
  endtask

  task automatic t_rearm_idle();
    wr(A_EN_MISC, 32'h01);
    quiet_cycles("R6 armed idle", 2);
    misc_req = 8'h01;
    @(negedge clk);
    check("R4 misc after idle rearm", {28'd0, irqs()}, 32'h8);
    clean();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog (all requirements): actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    rxthr_req = '0; rx_req = '0; tx_req = '0; misc_req = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_enable_rw();
    t_status_mask();
    t_disabled();
    t_pulse_and_disarm();
    t_eoi_select();
    t_status_write();
    t_rearm_idle();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule